// File: doc/BRIEF.md
# CAMAC LAM Request Controller

This block holds the look-at-me (LAM) request state of a CAMAC slave. A decoded function code, subaddress, strobe and write word arrive from the dataway sequencer. A small set of command codes lets the crate controller clear source bits, read or write the source and mask registers, and switch LAM on or off in software. Internal event pulses, such as a receive or transmit FIFO filling up, set source bits directly.

The LAM output is held in a register. A two-state sequencer decides when that register is refreshed. In `ST_IDLE` the output holds its value. Any register-changing command, any event pulse, or the periodic tick moves the sequencer to `ST_EVAL` (transition *request*). In `ST_EVAL` the LAM output is loaded from the enable flag and the source and mask registers. The sequencer then returns to `ST_IDLE` (transition *settle*), or stays in `ST_EVAL` if another request is pending (transition *chain*).

Top module: `lam_ctrl`

## Requirements
- R1: After reset the source register and mask register are all zero, `lam_en` is 0 and `lam` is 0.
- R2: A strobed function 10 with subaddress n, for n below NUM_CLR (0, 1, 2 by default), clears source bit n and leaves the other bits unchanged.
- R3: A strobed function 10 with subaddress 15 clears every source bit.
- R4: A strobed function 7 returns the source register for subaddress 0 and the mask register for subaddress 1. `rd_valid` is high for the one cycle after the sampling edge, and `rd_data` carries the value the register held just before that edge.
- R5: A strobed function 22 loads `cmd_wdata` into the source register for subaddress 0 and into the mask register for subaddress 1.
- R6: A strobed function 26 with subaddress 0 sets `lam_en`, and a strobed function 24 with subaddress 0 clears it. Either change is visible after the sampling edge.
- R7: `lam` equals `lam_en` AND (OR-reduction of source AND mask). It is refreshed at the second rising edge after a register-changing command, an event pulse or a `tick` is sampled.
- R8: An `evt_set[i]` pulse sets source bit i. Bit 0 is the receive-FIFO-full event and bit 1 is the transmit-FIFO-full event.
- R9: When an event pulse and a clear or source write affect the same bit in the same cycle, the bit ends up set.
- R10: Other function codes, function 10 with subaddress 3 to 14, function 7 or 22 with subaddress 2 to 15, and function 24 or 26 with a nonzero subaddress change no register, leave `lam_en` unchanged and raise no `rd_valid`.
- R11: When `cmd_stb` is low, the function, subaddress and write word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stb | input | 1 | Command strobe, one cycle per command |
| cmd_fn | input | 5 | Decoded function code |
| cmd_sa | input | 4 | Decoded subaddress |
| cmd_wdata | input | REG_W | Write word for source or mask |
| evt_set | input | NUM_EVT | Event pulses that set source bits |
| tick | input | 1 | Periodic re-evaluation pulse |
| rd_data | output | REG_W | Register read result |
| rd_valid | output | 1 | Read result valid |
| lam | output | 1 | LAM request |
| lam_en | output | 1 | Software LAM enable indicator |

## Verification
The bench builds the block with REG_W=16, NUM_EVT=2 and NUM_CLR=3. With these values every single-bit clear subaddress can be used, including the boundary subaddress 3, which must be ignored. Both FIFO event inputs can be driven against a clear or a write in the same cycle, and the full 16-bit mask can be exercised against sparse source patterns. Reads are scored against a queue of expected words, so a missing or extra `rd_valid` is reported as well as a wrong value.

// File: rtl/lam_pkg.sv
package lam_pkg;
    localparam int FN_W = 5;
    localparam int SA_W = 4;

    localparam logic [FN_W-1:0] FN_READ    = 5'd7;
    localparam logic [FN_W-1:0] FN_CLEAR   = 5'd10;
    localparam logic [FN_W-1:0] FN_WRITE   = 5'd22;
    localparam logic [FN_W-1:0] FN_DISABLE = 5'd24;
    localparam logic [FN_W-1:0] FN_ENABLE  = 5'd26;

    localparam logic [SA_W-1:0] SA_SRC  = 4'd0;
    localparam logic [SA_W-1:0] SA_MASK = 4'd1;
    localparam logic [SA_W-1:0] SA_ALL  = 4'd15;

    typedef enum logic {
        ST_IDLE,
        ST_EVAL
    } lam_state_e;

    typedef struct packed {
        logic            rd_src;
        logic            rd_mask;
        logic            wr_src;
        logic            wr_mask;
        logic            clr_one;
        logic            clr_all;
        logic            lam_off;
        logic            lam_on;
        logic [SA_W-1:0] idx;
    } lam_op_t;
endpackage

// File: rtl/lam_cmd_dec.sv
module lam_cmd_dec
    import lam_pkg::*;
#(
    parameter int NUM_CLR = 3
) (
    input  logic            stb,
    input  logic [FN_W-1:0] fn,
    input  logic [SA_W-1:0] sa,
    output lam_op_t         op
);
    localparam int CLR_LIM = (NUM_CLR < 15) ? NUM_CLR : 15;

    logic sa_single;

    assign sa_single = (int'(sa) < CLR_LIM);

    always_comb begin
        op     = '0;
        op.idx = sa;
        if (stb) begin
            unique case (fn)
                FN_READ: begin
                    op.rd_src  = (sa == SA_SRC);
                    op.rd_mask = (sa == SA_MASK);
                end
                FN_WRITE: begin
                    op.wr_src  = (sa == SA_SRC);
                    op.wr_mask = (sa == SA_MASK);
                end
                FN_CLEAR: begin
                    op.clr_one = sa_single;
                    op.clr_all = (sa == SA_ALL);
                end
                FN_DISABLE: op.lam_off = (sa == SA_SRC);
                FN_ENABLE:  op.lam_on  = (sa == SA_SRC);
                default:    op.idx     = sa;
            endcase
        end
    end
endmodule

// File: rtl/lam_regs.sv
module lam_regs
    import lam_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int NUM_EVT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  lam_op_t            op,
    input  logic [REG_W-1:0]   wdata,
    input  logic [NUM_EVT-1:0] evt,
    output logic [REG_W-1:0]   src_q,
    output logic [REG_W-1:0]   mask_q,
    output logic               en_q,
    output logic [REG_W-1:0]   rd_data,
    output logic               rd_valid,
    output logic               upd
);
    localparam int EVT_USED = (NUM_EVT < REG_W) ? NUM_EVT : REG_W;

    logic [REG_W-1:0] src_d;
    logic [REG_W-1:0] mask_d;
    logic             en_d;

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        logic kept;
        always_comb begin
            kept = src_q[b];
            if (op.wr_src) begin
                kept = wdata[b];
            end else if (op.clr_all || (op.clr_one && (int'(op.idx) == b))) begin
                kept = 1'b0;
            end
        end
        if (b < EVT_USED) begin : g_evt
            assign src_d[b] = kept | evt[b];
        end else begin : g_plain
            assign src_d[b] = kept;
        end
    end

    assign mask_d = op.wr_mask ? wdata : mask_q;

    always_comb begin
        en_d = en_q;
        if (op.lam_on) begin
            en_d = 1'b1;
        end else if (op.lam_off) begin
            en_d = 1'b0;
        end
    end

    assign upd = op.wr_src | op.wr_mask | op.clr_one | op.clr_all
               | op.lam_on | op.lam_off | (|evt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= '0;
            mask_q   <= '0;
            en_q     <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            src_q    <= src_d;
            mask_q   <= mask_d;
            en_q     <= en_d;
            rd_valid <= op.rd_src | op.rd_mask;
            if (op.rd_src) begin
                rd_data <= src_q;
            end else if (op.rd_mask) begin
                rd_data <= mask_q;
            end
        end
    end
endmodule

// File: rtl/lam_eval_fsm.sv
module lam_eval_fsm
    import lam_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [REG_W-1:0] src_q,
    input  logic [REG_W-1:0] mask_q,
    input  logic             en_q,
    output logic             lam
);
    lam_state_e state_q;
    lam_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req ? ST_EVAL : ST_IDLE;
            ST_EVAL: state_d = req ? ST_EVAL : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lam <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: lam <= lam;
                ST_EVAL: lam <= en_q & (|(src_q & mask_q));
            endcase
        end
    end
endmodule

// File: rtl/lam_ctrl.sv
module lam_ctrl
    import lam_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int NUM_EVT = 2,
    parameter int NUM_CLR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_stb,
    input  logic [4:0]         cmd_fn,
    input  logic [3:0]         cmd_sa,
    input  logic [REG_W-1:0]   cmd_wdata,
    input  logic [NUM_EVT-1:0] evt_set,
    input  logic               tick,
    output logic [REG_W-1:0]   rd_data,
    output logic               rd_valid,
    output logic               lam,
    output logic               lam_en
);
    lam_op_t          op;
    logic [REG_W-1:0] src_q;
    logic [REG_W-1:0] mask_q;
    logic             en_q;
    logic             upd;

    lam_cmd_dec #(
        .NUM_CLR (NUM_CLR)
    ) u_dec (
        .stb (cmd_stb),
        .fn  (cmd_fn),
        .sa  (cmd_sa),
        .op  (op)
    );

    lam_regs #(
        .REG_W   (REG_W),
        .NUM_EVT (NUM_EVT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .wdata    (cmd_wdata),
        .evt      (evt_set),
        .src_q    (src_q),
        .mask_q   (mask_q),
        .en_q     (en_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .upd      (upd)
    );

    lam_eval_fsm #(
        .REG_W (REG_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (upd | tick),
        .src_q  (src_q),
        .mask_q (mask_q),
        .en_q   (en_q),
        .lam    (lam)
    );

    assign lam_en = en_q;
endmodule

// File: rtl/lam_ctrl_chk.sv
module lam_ctrl_chk
    import lam_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int NUM_EVT = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_stb,
    input logic [4:0]         cmd_fn,
    input logic [3:0]         cmd_sa,
    input logic [REG_W-1:0]   cmd_wdata,
    input logic [NUM_EVT-1:0] evt_set,
    input logic               rd_valid,
    input logic               lam,
    input logic               lam_en,
    input logic [REG_W-1:0]   src_q,
    input logic [REG_W-1:0]   mask_q
);
    AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_fn == FN_CLEAR && cmd_sa == SA_ALL && !(|evt_set)) |=> (src_q == '0)); // R3

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_fn == FN_CLEAR && cmd_sa == 4'd0 && evt_set[0]) |=> src_q[0]); // R9

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_fn == FN_WRITE && cmd_sa == SA_MASK) |=> (mask_q == $past(cmd_wdata))); // R5

    AST_EN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_fn == FN_ENABLE && cmd_sa == 4'd0) |=> lam_en); // R6

    AST_LAM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        lam |-> $past(lam_en)); // R7

    AST_RD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_stb && cmd_fn == FN_READ && cmd_sa <= SA_MASK)); // R4

    AST_IDLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_stb) |=> $stable(mask_q)); // R11
endmodule

bind lam_ctrl lam_ctrl_chk #(
    .REG_W   (REG_W),
    .NUM_EVT (NUM_EVT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_stb   (cmd_stb),
    .cmd_fn    (cmd_fn),
    .cmd_sa    (cmd_sa),
    .cmd_wdata (cmd_wdata),
    .evt_set   (evt_set),
    .rd_valid  (rd_valid),
    .lam       (lam),
    .lam_en    (lam_en),
    .src_q     (src_q),
    .mask_q    (mask_q)
);

// File: tb/test_lam_ctrl.sv
`timescale 1ns/1ps
module test_lam_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_stb;
    logic [4:0]  cmd_fn;
    logic [3:0]  cmd_sa;
    logic [15:0] cmd_wdata;
    logic [1:0]  evt_set;
    logic        tick;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        lam;
    logic        lam_en;

    always #2.5 clk = ~clk;

    lam_ctrl #(.REG_W(16), .NUM_EVT(2), .NUM_CLR(3)) i_lam_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_stb   (cmd_stb),
        .cmd_fn    (cmd_fn),
        .cmd_sa    (cmd_sa),
        .cmd_wdata (cmd_wdata),
        .evt_set   (evt_set),
        .tick      (tick),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .lam       (lam),
        .lam_en    (lam_en)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] m_src;
    logic [15:0] m_mask;
    logic        m_en;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a read result appears
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rd_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R10 unexpected read: got %h expected no rd_valid", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // driver: applies one cycle of inputs, updates the model, queues reads
    task automatic do_cmd(input bit stb, input logic [4:0] fn, input logic [3:0] sa,
                          input logic [15:0] wd, input logic [1:0] ev, input string tag);
        logic [15:0] nsrc;
        cmd_stb = stb; cmd_fn = fn; cmd_sa = sa; cmd_wdata = wd; evt_set = ev;
        nsrc = m_src;
        if (stb) begin
            if (fn == 5'd7 && sa == 4'd0) begin exp_q.push_back(m_src);  tag_q.push_back(tag); end
            if (fn == 5'd7 && sa == 4'd1) begin exp_q.push_back(m_mask); tag_q.push_back(tag); end
            if (fn == 5'd22 && sa == 4'd0) nsrc = wd;
            if (fn == 5'd22 && sa == 4'd1) m_mask = wd;
            if (fn == 5'd10 && sa < 4'd3) nsrc[sa] = 1'b0;
            if (fn == 5'd10 && sa == 4'd15) nsrc = '0;
            if (fn == 5'd26 && sa == 4'd0) m_en = 1'b1;
            if (fn == 5'd24 && sa == 4'd0) m_en = 1'b0;
        end
        m_src = nsrc | {14'd0, ev};
        @(negedge clk);
        cmd_stb = 1'b0; cmd_fn = '0; cmd_sa = '0; cmd_wdata = '0; evt_set = '0;
    endtask

    task automatic chk_lam(input string tag);
        @(negedge clk);
        check(tag, {15'd0, lam}, {15'd0, m_en & (|(m_src & m_mask))});
    endtask

    task automatic rd_both(input string tag);
        do_cmd(1'b1, 5'd7, 4'd0, 16'h0, 2'b00, {tag, " src"});
        do_cmd(1'b1, 5'd7, 4'd1, 16'h0, 2'b00, {tag, " mask"});
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_src = '0; m_mask = '0; m_en = 1'b0;
        rst_n = 1'b0; cmd_stb = 1'b0; cmd_fn = '0; cmd_sa = '0;
        cmd_wdata = '0; evt_set = '0; tick = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 lam after reset", {15'd0, lam}, 16'd0);
        check("R1 lam_en after reset", {15'd0, lam_en}, 16'd0);
        rd_both("R1 reset");

        do_cmd(1'b1, 5'd22, 4'd1, 16'h0005, 2'b00, "R5 mask write");
        do_cmd(1'b1, 5'd22, 4'd0, 16'h0004, 2'b00, "R5 src write");
        rd_both("R5 readback");
        chk_lam("R7 lam off while disabled");

        do_cmd(1'b1, 5'd26, 4'd0, 16'h0, 2'b00, "R6 enable");
        check("R6 lam_en set", {15'd0, lam_en}, 16'd1);
        chk_lam("R7 lam on after enable");

        do_cmd(1'b1, 5'd10, 4'd2, 16'h0, 2'b00, "R2 clear bit2");
        chk_lam("R7 lam drops after clear");
        do_cmd(1'b1, 5'd7, 4'd0, 16'h0, 2'b00, "R2 src after clear bit2");

        do_cmd(1'b1, 5'd0, 4'd0, 16'h0, 2'b01, "R8 rx full event");
        chk_lam("R8 lam from rx full event");
        do_cmd(1'b1, 5'd10, 4'd0, 16'h0, 2'b01, "R9 clear vs event");
        do_cmd(1'b1, 5'd7, 4'd0, 16'h0, 2'b00, "R9 src bit0 kept");
        do_cmd(1'b1, 5'd10, 4'd0, 16'h0, 2'b00, "R2 clear bit0");
        chk_lam("R7 lam after clear bit0");
        do_cmd(1'b1, 5'd7, 4'd0, 16'h0, 2'b00, "R2 src after clear bit0");

        do_cmd(1'b1, 5'd22, 4'd0, 16'hFFFF, 2'b00, "R5 src all ones");
        do_cmd(1'b1, 5'd10, 4'd1, 16'h0, 2'b00, "R2 clear bit1");
        do_cmd(1'b1, 5'd10, 4'd3, 16'h0, 2'b00, "R10 clear sa3");
        do_cmd(1'b1, 5'd10, 4'd5, 16'h0, 2'b00, "R10 clear sa5");
        do_cmd(1'b1, 5'd7, 4'd0, 16'h0, 2'b00, "R2 R10 src FFFD");
        do_cmd(1'b1, 5'd7, 4'd3, 16'h0, 2'b00, "R10 read sa3");
        check("R10 no rd_valid for read sa3", {15'd0, rd_valid}, 16'd0);
        do_cmd(1'b1, 5'd22, 4'd2, 16'h1234, 2'b00, "R10 write sa2");
        do_cmd(1'b1, 5'd24, 4'd1, 16'h0, 2'b00, "R10 disable sa1");
        check("R10 lam_en kept", {15'd0, lam_en}, 16'd1);
        do_cmd(1'b1, 5'd3, 4'd0, 16'hAAAA, 2'b00, "R10 unused fn");
        rd_both("R10 after ignored codes");
        chk_lam("R7 lam with FFFD and 0005");

        do_cmd(1'b0, 5'd22, 4'd1, 16'hFFFF, 2'b00, "R11 no strobe");
        do_cmd(1'b0, 5'd10, 4'd15, 16'h0, 2'b00, "R11 no strobe clr");
        rd_both("R11 unchanged");

        do_cmd(1'b1, 5'd10, 4'd15, 16'h0, 2'b00, "R3 clear all");
        do_cmd(1'b1, 5'd7, 4'd0, 16'h0, 2'b00, "R3 src zero");
        chk_lam("R3 lam after clear all");

        do_cmd(1'b1, 5'd22, 4'd0, 16'h0000, 2'b10, "R9 write vs tx event");
        do_cmd(1'b1, 5'd7, 4'd0, 16'h0, 2'b00, "R9 src 0002");
        do_cmd(1'b1, 5'd22, 4'd1, 16'h0002, 2'b00, "R5 mask 0002");
        chk_lam("R8 lam from tx full event");

        do_cmd(1'b1, 5'd24, 4'd0, 16'h0, 2'b00, "R6 disable");
        check("R6 lam_en cleared", {15'd0, lam_en}, 16'd0);
        chk_lam("R7 lam off when disabled");

        do_cmd(1'b1, 5'd26, 4'd0, 16'h0, 2'b00, "R6 re-enable");
        chk_lam("R7 lam back on");
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk_lam("R7 lam after tick");

        repeat (3) @(negedge clk);
        check("R4 scoreboard drained", 16'(exp_q.size()), 16'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule